// File: doc/BRIEF.md
# Three-Phase Charge-Transfer Clock Sequencer

This block produces the logic-level electrode enables that walk charge through a charge-coupled image sensor. It drives three vertical lines for the image area and three horizontal lines for the serial output row. It also drives a shutter enable and a one-cycle strobe that tells the downstream digitizer when a pixel has reached the output amplifier. Analog levels, the amplifier and the converter sit outside the block.

A pulse on `start` while the block is idle begins one frame. The block captures the exposure length and the row and column counts at that moment. It opens the shutter for the exposure period and then closes it. For each row, it first shifts the image area down by one row, which moves a row into the output register. It then clocks that register once per column and strobes `sample` after each horizontal move. Every move is make-before-break: the next electrode rises while the current one is still high, and only then does the current one fall. Each electrode pattern dwells for a fixed number of cycles set by a parameter.

States: IDLE, INTEG (shutter open), CLOSE (one settle cycle), VSHIFT (row move), HSHIFT (pixel move), SAMPLE (strobe) and DONE (end pulse). Transitions:
- IDLE→INTEG on an accepted start.
- INTEG→CLOSE when the exposure count is spent.
- CLOSE→VSHIFT.
- VSHIFT→HSHIFT when the row move completes.
- HSHIFT→SAMPLE when the pixel move completes.
- SAMPLE→HSHIFT while columns remain in the row.
- SAMPLE→VSHIFT when the row is finished but rows remain.
- SAMPLE→DONE after the last pixel.
- DONE→IDLE.

Top module: `ccd_clock_seq`

## Requirements
- R1: After reset, and while reset is held, `busy`, `shutter`, `sample` and `frame_done` are low. Both phase buses rest at 3'b010, where bit 0 is electrode 1, bit 1 is electrode 2 and bit 2 is electrode 3.
- R2: A start sampled high in IDLE raises `busy` at the next edge. `shutter` is then high for exactly max(int_len,1) cycles, starting with the first busy cycle.
- R3: Each move on either bus walks the pattern 010→110→100→101→001→011→010. Every change flips exactly one line, and 000 or 111 never appears.
- R4: Every pattern of a move other than the resting 010 holds for exactly DWELL cycles. A full move takes 6×DWELL cycles.
- R5: The frame order is: exposure, one closed cycle, then for each row one vertical move followed by, per column, one horizontal move and one strobe cycle. The frame length is L+1+R×(6D+C×(6D+1))+1 cycles.
- R6: The vertical bus rests at 010 whenever the horizontal bus is moving, and the horizontal bus rests whenever the vertical bus is moving. Both buses rest while the shutter is open.
- R7: `sample` is a one-cycle pulse, issued the cycle after each horizontal move ends, exactly R×C times per frame.
- R8: `frame_done` is high for one cycle, in the cycle after the last strobe. `busy` is high through that cycle and low at the next.
- R9: A start that arrives while `busy` is high is ignored. Changes to int_len, row_count or col_count during a frame have no effect on it.
- R10: A zero exposure length, row count or column count acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted only when idle |
| int_len | input | INT_W | Exposure length in cycles |
| row_count | input | ROW_W | Rows per frame |
| col_count | input | COL_W | Columns per row |
| v_phase | output | 3 | Image-area electrode enables, bit 0 = electrode 1 |
| h_phase | output | 3 | Output-register electrode enables, bit 0 = electrode 1 |
| shutter | output | 1 | Shutter open |
| sample | output | 1 | One-cycle digitizer strobe per pixel |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
`busy` is due one edge after an accepted start, and the bench counts frame cycles from that first busy cycle. The shutter is then expected in cycles 1 to L. Each strobe is due one cycle after a horizontal move's last cycle, and `frame_done` is due in cycle L+1+R×(6D+C×(6D+1))+1, with `busy` low one edge later. Inputs change and outputs are sampled on falling edges, and the bench measures every phase pattern's run length and successor over the whole frame. Reset is asynchronous, so idle outputs are expected at the very next falling edge.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INTEG,
        S_CLOSE,
        S_VSHIFT,
        S_HSHIFT,
        S_SAMPLE,
        S_DONE
    } seq_state_t;

    // bit 0 = electrode 1, bit 1 = electrode 2, bit 2 = electrode 3
    localparam logic [2:0] PH_REST = 3'b010;
    localparam int unsigned STEPS_PER_MOVE = 6;

    function automatic logic [2:0] step_pattern(input logic [2:0] idx);
        logic [2:0] p;
        unique case (idx)
            3'd0:    p = 3'b110;
            3'd1:    p = 3'b100;
            3'd2:    p = 3'b101;
            3'd3:    p = 3'b001;
            3'd4:    p = 3'b011;
            default: p = 3'b010;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ccd_down_counter.sv
module ccd_down_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/ccd_phase_stepper.sv
module ccd_phase_stepper
    import ccd_seq_pkg::*;
#(
    parameter int DWELL = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    output logic [2:0] phase,
    output logic       done
);
    localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL - 1);
    localparam logic [2:0]    LAST_STEP  = 3'(STEPS_PER_MOVE - 1);

    logic          active_q;
    logic [2:0]    step_q;
    logic [DW-1:0] dwell_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            step_q   <= '0;
            dwell_q  <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            step_q   <= '0;
            dwell_q  <= '0;
        end else if (active_q) begin
            if (dwell_q == DWELL_LAST) begin
                dwell_q <= '0;
                if (step_q == LAST_STEP) begin
                    active_q <= 1'b0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end
    end

    assign phase = active_q ? step_pattern(step_q) : PH_REST;
    assign done  = active_q && (step_q == LAST_STEP) && (dwell_q == DWELL_LAST);
endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
    import ccd_seq_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    parameter int INT_W = 16,
    parameter int DWELL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [INT_W-1:0] int_len,
    input  logic [ROW_W-1:0] row_count,
    input  logic [COL_W-1:0] col_count,
    output logic [2:0]       v_phase,
    output logic [2:0]       h_phase,
    output logic             shutter,
    output logic             sample,
    output logic             busy,
    output logic             frame_done
);
    seq_state_t state_q, state_d;

    logic load_all, int_dec, row_dec, col_dec, v_go, h_go;
    logic int_zero, row_zero, col_zero, v_done, h_done;
    logic [COL_W-1:0] cols_q;
    logic [INT_W-1:0] int_load;
    logic [ROW_W-1:0] row_load;
    logic [COL_W-1:0] col_load;

    // counts hold "remaining minus one"; zero requests act as one
    assign int_load = (int_len   == '0) ? '0 : int_len   - 1'b1;
    assign row_load = (row_count == '0) ? '0 : row_count - 1'b1;
    assign col_load = (cols_q    == '0) ? '0 : cols_q    - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cols_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_all) cols_q <= col_count;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_all = 1'b0;
        int_dec  = 1'b0;
        row_dec  = 1'b0;
        col_dec  = 1'b0;
        v_go     = 1'b0;
        h_go     = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                load_all = 1'b1;
                state_d  = S_INTEG;
            end
            S_INTEG: if (int_zero) state_d = S_CLOSE;
                     else          int_dec = 1'b1;
            S_CLOSE: begin
                v_go    = 1'b1;
                state_d = S_VSHIFT;
            end
            S_VSHIFT: if (v_done) begin
                h_go    = 1'b1;
                state_d = S_HSHIFT;
            end
            S_HSHIFT: if (h_done) state_d = S_SAMPLE;
            S_SAMPLE: begin
                if (!col_zero) begin
                    col_dec = 1'b1;
                    h_go    = 1'b1;
                    state_d = S_HSHIFT;
                end else if (!row_zero) begin
                    row_dec = 1'b1;
                    v_go    = 1'b1;
                    state_d = S_VSHIFT;
                end else begin
                    state_d = S_DONE;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        shutter    = (state_q == S_INTEG);
        sample     = (state_q == S_SAMPLE);
        frame_done = (state_q == S_DONE);
        busy       = (state_q != S_IDLE);
    end

    ccd_down_counter #(.W(INT_W)) u_int_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_all), .load_val(int_load),
        .dec(int_dec), .is_zero(int_zero)
    );

    ccd_down_counter #(.W(ROW_W)) u_row_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_all), .load_val(row_load),
        .dec(row_dec), .is_zero(row_zero)
    );

    ccd_down_counter #(.W(COL_W)) u_col_cnt (
        .clk(clk), .rst_n(rst_n), .load(v_go), .load_val(col_load),
        .dec(col_dec), .is_zero(col_zero)
    );

    ccd_phase_stepper #(.DWELL(DWELL)) u_v_step (
        .clk(clk), .rst_n(rst_n), .go(v_go), .phase(v_phase), .done(v_done)
    );

    ccd_phase_stepper #(.DWELL(DWELL)) u_h_step (
        .clk(clk), .rst_n(rst_n), .go(h_go), .phase(h_phase), .done(h_done)
    );
endmodule

// File: rtl/ccd_clock_seq_chk.sv
module ccd_clock_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] v_phase,
    input logic [2:0] h_phase,
    input logic       shutter,
    input logic       sample,
    input logic       busy,
    input logic       frame_done
);
    localparam logic [2:0] REST = 3'b010;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !shutter && !sample && !frame_done
                    && v_phase == REST && h_phase == REST));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(v_phase) == 1 || $countones(v_phase) == 2)
        && ($countones(h_phase) == 1 || $countones(h_phase) == 2));

    assert_v_one_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_phase != $past(v_phase)) |-> $countones(v_phase ^ $past(v_phase)) == 1);

    assert_h_one_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_phase != $past(h_phase)) |-> $countones(h_phase ^ $past(h_phase)) == 1);

    assert_axes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(v_phase != REST && h_phase != REST));

    assert_shutter_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shutter |-> (v_phase == REST && h_phase == REST && !sample));

    assert_sample_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy);

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind ccd_clock_seq ccd_clock_seq_chk u_chk (.*);

// File: tb/ccd_clock_seq_bench.sv
module ccd_clock_seq_bench;
    localparam int ROW_W = 11;
    localparam int COL_W = 11;
    localparam int INT_W = 16;
    localparam int D     = 2;
    localparam int NV    = 6;
    localparam logic [2:0] REST = 3'b010;

    // {int_len, rows, cols, frame cycles, strobes, shutter cycles}
    localparam int VEC [NV][6] = '{
        '{3, 1, 1,  30, 1, 3},
        '{5, 2, 3, 109, 6, 5},
        '{0, 3, 2, 117, 6, 1},
        '{2, 1, 4,  68, 4, 2},
        '{1, 4, 1, 103, 4, 1},
        '{0, 0, 0,  28, 1, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [INT_W-1:0] int_len = '0;
    logic [ROW_W-1:0] row_count = '0;
    logic [COL_W-1:0] col_count = '0;
    logic [2:0]       v_phase, h_phase;
    logic             shutter, sample, busy, frame_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ccd_clock_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W), .DWELL(D)) u_ccd_clock_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .int_len(int_len),
        .row_count(row_count), .col_count(col_count), .v_phase(v_phase),
        .h_phase(h_phase), .shutter(shutter), .sample(sample), .busy(busy),
        .frame_done(frame_done)
    );

    function automatic logic [2:0] succ(input logic [2:0] p);
        case (p)
            3'b010:  return 3'b110;
            3'b110:  return 3'b100;
            3'b100:  return 3'b101;
            3'b101:  return 3'b001;
            3'b001:  return 3'b011;
            default: return 3'b010;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(!busy && !shutter && !sample && !frame_done, req,
            {busy, shutter, sample, frame_done}, 0);
        chk(v_phase == REST && h_phase == REST, req, {v_phase, h_phase}, {REST, REST});
    endtask

    task automatic run_frame(input int l, input int r, input int c, input int ef,
                             input int es, input int esh, input int inj);
        int cyc = 0, samp = 0, shc = 0, done_at = 0, done_n = 0;
        int order_bad = 0, dwell_bad = 0, excl_bad = 0, sh_bad = 0, pulse_bad = 0;
        int rv = 0, rh = 0;
        logic [2:0] pv = REST, ph = REST;
        logic prev_s = 1'b0;
        @(negedge clk);
        int_len = INT_W'(l); row_count = ROW_W'(r); col_count = COL_W'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 busy after start", busy, 1);
        while (busy && cyc < 100000) begin
            cyc++;
            if (shutter) shc++;
            if (shutter != (cyc <= esh)) sh_bad++;
            if (sample) begin samp++; if (prev_s) pulse_bad++; end
            prev_s = sample;
            if (frame_done) begin done_at = cyc; done_n++; end
            if (v_phase != REST && h_phase != REST) excl_bad++;
            if (shutter && (v_phase != REST || h_phase != REST)) excl_bad++;
            if (v_phase != pv) begin
                if (v_phase != succ(pv)) order_bad++;
                if (pv != REST && rv != D) dwell_bad++;
                pv = v_phase; rv = 1;
            end else rv++;
            if (h_phase != ph) begin
                if (h_phase != succ(ph)) order_bad++;
                if (ph != REST && rh != D) dwell_bad++;
                ph = h_phase; rh = 1;
            end else rh++;
            if (cyc == inj) begin
                start = 1'b1; int_len = 16'd7; row_count = 11'd9; col_count = 11'd9;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(cyc == ef,        "R5 frame length", cyc, ef);
        chk(samp == es,       "R7 strobe count", samp, es);
        chk(pulse_bad == 0,   "R7 strobe width", pulse_bad, 0);
        chk(shc == esh && sh_bad == 0, "R2 shutter window", shc, esh);
        chk(done_at == ef && done_n == 1, "R8 frame_done position", done_at, ef);
        chk(order_bad == 0,   "R3 pattern order", order_bad, 0);
        chk(dwell_bad == 0,   "R4 dwell length", dwell_bad, 0);
        chk(excl_bad == 0,    "R6 axes static", excl_bad, 0);
        if (inj > 0) begin
            repeat (3) @(negedge clk);
            chk(!busy, "R9 ignored start left no frame", busy, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog actual hung expected frame end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        chk_idle("R1 held in reset");
        start = 1'b1;
        @(negedge clk);
        chk_idle("R1 start during reset");
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after release");

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], 0);
            repeat (2) @(negedge clk);
        end

        // R9: start and new counts mid-frame, in the exposure and in a shift
        run_frame(5, 2, 3, 109, 6, 5, 3);
        run_frame(2, 1, 4, 68, 4, 2, 40);

        // R10 longer exposure boundary and wide row
        run_frame(20, 1, 6, 20 + 1 + 12 + 6 * 13 + 1, 6, 20, 0);

        // R1 asynchronous reset mid-frame
        @(negedge clk);
        int_len = 16'd2; row_count = 11'd2; col_count = 11'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_idle("R1 reset mid-frame");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after mid-frame reset");
        run_frame(3, 1, 1, 30, 1, 3, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule